// File: doc/BRIEF.md
# Display Engine Run and Update Controller

This block is the control core of a display engine, reached through a simple register read/write port. It owns the start, stop and commit controls of the engine, the choice between a continuous video interface and a software-paced command interface, the tearing-effect input options, and an interrupt unit with enable, write-one-to-clear and status registers. A separate timing or transfer engine supplies frame-done and frame-boundary pulses and an underflow indication, and it follows `running_o`, `mode_cmd_o`, `halt_en_o` and `cfg_active_o`.

The two interface modes commit configuration in different ways. In video mode the configuration word is double-buffered. Software writes the staged copy and then asks for an update. A request made while stopped is committed at once. A request made while running waits for the next frame boundary, and both cases report update done. In command mode there is no shadow copy. The staged word is captured only when a run request starts the engine, and each frame-done pulse ends the frame that the run request began.

Top module: `dispc_ctrl_core`

## Requirements
- R1: After reset, every status and enable bit is 0, the engine is stopped, the interface is video mode, the active configuration is 0 and `irq_o` is low.
- R2: A status bit is set by its event whether or not it is enabled. `irq_o` is a register that holds the OR of (status AND enable) from the previous cycle. The enable register is at offset 0x1E0 and the status register at 0x1E8, with bit 0 done, bit 1 tearing effect, bit 2 underflow, bit 4 update done and bit 5 vsync.
- R3: Writing to the clear register at 0x1E4 clears each status bit whose data bit is 1 and leaves the others set. Writing 0xFF clears every status bit.
- R4: In video mode (bit 0 of the config register at 0x08 is 0), an update request (bit 2 of the control register at 0x04) made while stopped copies the staged word into the active word and sets status bit 4.
- R5: In video mode while running, an update request is held pending. The next frame-boundary pulse then commits it and sets status bit 4. Every frame-boundary pulse while running in video mode sets status bit 5.
- R6: In command mode (config bit 0 is 1), an update request has no effect. A run request (control bit 0) made while stopped captures the staged word into the active word. A run request made while running changes nothing.
- R7: In video mode, a stop request (control bit 1) made while running is held pending until the next frame-done pulse. That pulse clears the running state and sets status bit 0. A frame-done pulse with no stop pending has no effect.
- R8: In command mode, a frame-done pulse while running clears the running state and sets status bit 0.
- R9: The tearing-effect input passes through a two-flop synchronizer. Its rising edge sets status bit 1 only when bit 8 of the interface control register at 0x1F0 is 1. Bit 10 selects the pad input (1) or the internal input (0).
- R10: An underflow pulse sets status bit 2.
- R11: The control bits are one-cycle pulses. Reading 0x04 returns running in bit 0, stop pending in bit 1 and update pending in bit 2. Reads return data one cycle after `rd_en_i`. Bits 8, 10 and 16 of 0x1F0 read back, and bit 16 drives `halt_en_o`. The staged word is at 0x24 and the read-only active word is at 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| frame_done_i | input | 1 | Frame-done pulse from the transfer engine |
| frame_bound_i | input | 1 | Frame-boundary (vsync) pulse |
| underflow_i | input | 1 | Pixel underflow pulse |
| te_pad_i | input | 1 | Tearing-effect signal from the pad, asynchronous |
| te_int_i | input | 1 | Tearing-effect signal from the internal source, asynchronous |
| irq_o | output | 1 | Interrupt request |
| running_o | output | 1 | Engine running |
| mode_cmd_o | output | 1 | 1 for command mode, 0 for video mode |
| halt_en_o | output | 1 | Halt enable to the interface |
| cfg_active_o | output | CFG_W | Active configuration word |

## Verification
The assertions check on every cycle that `irq_o` stays low after a cycle with no status bit set, and that the running state falls only after a frame-done pulse. They also check that the active word cannot change in command mode without a run request, and that the tearing-effect, underflow and vsync status bits rise only after their own causes. Only the bench's scenarios can show the values that are committed, the deferral of a video-mode update until a frame boundary, the completion of a stop, the partial clears and the register read-back.

// File: rtl/dispc_pkg.sv
package dispc_pkg;
  localparam logic [11:0] OFF_CTRL   = 12'h004;
  localparam logic [11:0] OFF_CFG    = 12'h008;
  localparam logic [11:0] OFF_STAGE  = 12'h024;
  localparam logic [11:0] OFF_ACTIVE = 12'h028;
  localparam logic [11:0] OFF_INT_EN = 12'h1E0;
  localparam logic [11:0] OFF_INT_CL = 12'h1E4;
  localparam logic [11:0] OFF_INT_ST = 12'h1E8;
  localparam logic [11:0] OFF_IFCTL  = 12'h1F0;

  localparam int CB_RUN  = 0;
  localparam int CB_STOP = 1;
  localparam int CB_UPD  = 2;

  localparam int IB_DONE  = 0;
  localparam int IB_TE    = 1;
  localparam int IB_ERR   = 2;
  localparam int IB_UPD   = 4;
  localparam int IB_VSYNC = 5;

  localparam int FB_TE_EN  = 8;
  localparam int FB_TE_EXT = 10;
  localparam int FB_HALT   = 16;

  typedef enum logic {
    MODE_VIDEO = 1'b0,
    MODE_CMD   = 1'b1
  } if_mode_e;
endpackage

// File: rtl/dispc_te_sync.sv
module dispc_te_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  input  logic int_i,
  input  logic sel_ext_i,
  input  logic en_i,
  output logic evt_o
);
  localparam int NSRC = 2;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] synced;
  logic prev_q;
  logic cur;

  assign src = {pad_i, int_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], src[s]};
    end
    assign synced[s] = chain_q[STAGES-1];
  end

  assign cur = sel_ext_i ? synced[1] : synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      evt_o  <= 1'b0;
    end else begin
      prev_q <= cur;
      evt_o  <= en_i & cur & ~prev_q;
    end
  end
endmodule

// File: rtl/dispc_irq_unit.sv
module dispc_irq_unit #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             en_wr_i,
  input  logic             clr_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] en_o,
  output logic [IRQ_W-1:0] sts_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] clr_mask;
  assign clr_mask = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o  <= '0;
      sts_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (en_wr_i) en_o <= wdata_i;
      sts_o <= (sts_o & ~clr_mask) | set_i;
      irq_o <= |(sts_o & en_o);
    end
  end
endmodule

// File: rtl/dispc_seq.sv
module dispc_seq #(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_cmd_i,
  input  logic             run_req_i,
  input  logic             stop_req_i,
  input  logic             upd_req_i,
  input  logic             frame_done_i,
  input  logic             frame_bound_i,
  input  logic [CFG_W-1:0] staged_i,
  output logic             running_o,
  output logic             stop_pend_o,
  output logic             upd_pend_o,
  output logic [CFG_W-1:0] active_o,
  output logic             evt_done_o,
  output logic             evt_upd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running_o   <= 1'b0;
      stop_pend_o <= 1'b0;
      upd_pend_o  <= 1'b0;
      active_o    <= '0;
      evt_done_o  <= 1'b0;
      evt_upd_o   <= 1'b0;
    end else begin
      evt_done_o <= 1'b0;
      evt_upd_o  <= 1'b0;
      if (mode_cmd_i) begin
        stop_pend_o <= 1'b0;
        upd_pend_o  <= 1'b0;
        if (run_req_i && !running_o) begin
          running_o <= 1'b1;
          active_o  <= staged_i;
        end else if (running_o && frame_done_i) begin
          running_o  <= 1'b0;
          evt_done_o <= 1'b1;
        end
      end else begin
        if (run_req_i && !running_o) running_o <= 1'b1;
        if (stop_req_i && running_o) stop_pend_o <= 1'b1;
        if (frame_done_i && stop_pend_o) begin
          running_o   <= 1'b0;
          stop_pend_o <= 1'b0;
          evt_done_o  <= 1'b1;
        end
        if (upd_req_i) begin
          if (!running_o) begin
            active_o  <= staged_i;
            evt_upd_o <= 1'b1;
          end else begin
            upd_pend_o <= 1'b1;
          end
        end
        if (frame_bound_i && upd_pend_o) begin
          active_o   <= staged_i;
          upd_pend_o <= 1'b0;
          evt_upd_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dispc_ctrl_core.sv
module dispc_ctrl_core
  import dispc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CFG_W     = 32,
  parameter int IRQ_W     = 8,
  parameter int TE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_done_i,
  input  logic              frame_bound_i,
  input  logic              underflow_i,
  input  logic              te_pad_i,
  input  logic              te_int_i,
  output logic              irq_o,
  output logic              running_o,
  output logic              mode_cmd_o,
  output logic              halt_en_o,
  output logic [CFG_W-1:0]  cfg_active_o
);
  if_mode_e         mode_q;
  logic             te_en_q, te_ext_q, halt_q;
  logic [CFG_W-1:0] staged_q;

  logic hit_ctrl, hit_cfg, hit_stage, hit_en, hit_clr, hit_ifctl;
  logic run_req, stop_req, upd_req;
  logic stop_pend, upd_pend, evt_done, evt_upd, te_evt, vsync_evt;
  logic [IRQ_W-1:0] set_w, en_w, sts_w;

  assign hit_ctrl  = wr_en_i && addr_i == ADDR_W'(OFF_CTRL);
  assign hit_cfg   = wr_en_i && addr_i == ADDR_W'(OFF_CFG);
  assign hit_stage = wr_en_i && addr_i == ADDR_W'(OFF_STAGE);
  assign hit_en    = wr_en_i && addr_i == ADDR_W'(OFF_INT_EN);
  assign hit_clr   = wr_en_i && addr_i == ADDR_W'(OFF_INT_CL);
  assign hit_ifctl = wr_en_i && addr_i == ADDR_W'(OFF_IFCTL);

  assign run_req  = hit_ctrl && wdata_i[CB_RUN];
  assign stop_req = hit_ctrl && wdata_i[CB_STOP];
  assign upd_req  = hit_ctrl && wdata_i[CB_UPD];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_VIDEO;
      te_en_q  <= 1'b0;
      te_ext_q <= 1'b0;
      halt_q   <= 1'b0;
      staged_q <= '0;
    end else begin
      if (hit_cfg) mode_q <= if_mode_e'(wdata_i[0]);
      if (hit_ifctl) begin
        te_en_q  <= wdata_i[FB_TE_EN];
        te_ext_q <= wdata_i[FB_TE_EXT];
        halt_q   <= wdata_i[FB_HALT];
      end
      if (hit_stage) staged_q <= wdata_i[CFG_W-1:0];
    end
  end

  dispc_seq #(.CFG_W(CFG_W)) seq_i (
    .clk(clk), .rst(rst),
    .mode_cmd_i(mode_q == MODE_CMD),
    .run_req_i(run_req), .stop_req_i(stop_req), .upd_req_i(upd_req),
    .frame_done_i(frame_done_i), .frame_bound_i(frame_bound_i),
    .staged_i(staged_q),
    .running_o(running_o), .stop_pend_o(stop_pend), .upd_pend_o(upd_pend),
    .active_o(cfg_active_o), .evt_done_o(evt_done), .evt_upd_o(evt_upd)
  );

  dispc_te_sync #(.STAGES(TE_STAGES)) te_i (
    .clk(clk), .rst(rst),
    .pad_i(te_pad_i), .int_i(te_int_i),
    .sel_ext_i(te_ext_q), .en_i(te_en_q),
    .evt_o(te_evt)
  );

  assign vsync_evt = frame_bound_i && running_o && mode_q == MODE_VIDEO;

  always_comb begin
    set_w           = '0;
    set_w[IB_DONE]  = evt_done;
    set_w[IB_TE]    = te_evt;
    set_w[IB_ERR]   = underflow_i;
    set_w[IB_UPD]   = evt_upd;
    set_w[IB_VSYNC] = vsync_evt;
  end

  dispc_irq_unit #(.IRQ_W(IRQ_W)) irq_i (
    .clk(clk), .rst(rst),
    .set_i(set_w), .en_wr_i(hit_en), .clr_wr_i(hit_clr),
    .wdata_i(wdata_i[IRQ_W-1:0]),
    .en_o(en_w), .sts_o(sts_w), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_CTRL):   rdata_o <= DATA_W'({upd_pend, stop_pend, running_o});
        ADDR_W'(OFF_CFG):    rdata_o <= DATA_W'(mode_q);
        ADDR_W'(OFF_STAGE):  rdata_o <= DATA_W'(staged_q);
        ADDR_W'(OFF_ACTIVE): rdata_o <= DATA_W'(cfg_active_o);
        ADDR_W'(OFF_INT_EN): rdata_o <= DATA_W'(en_w);
        ADDR_W'(OFF_INT_ST): rdata_o <= DATA_W'(sts_w);
        ADDR_W'(OFF_IFCTL):  rdata_o <= DATA_W'({halt_q, 5'b0, te_ext_q, 1'b0, te_en_q, 8'b0});
        default:             rdata_o <= '0;
      endcase
    end
  end

  assign mode_cmd_o = (mode_q == MODE_CMD);
  assign halt_en_o  = halt_q;
endmodule

// File: rtl/dispc_ctrl_core_chk.sv
module dispc_ctrl_core_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32,
  parameter int IRQ_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              frame_done_i,
  input logic              frame_bound_i,
  input logic              underflow_i,
  input logic              irq_o,
  input logic              running_o,
  input logic              mode_cmd_o,
  input logic [CFG_W-1:0]  cfg_active_o,
  input logic [IRQ_W-1:0]  sts_w,
  input logic              te_en_q
);
  logic run_wr;
  assign run_wr = wr_en_i && addr_i == ADDR_W'(dispc_pkg::OFF_CTRL) && wdata_i[dispc_pkg::CB_RUN];

  // R2
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_w == '0) |=> !irq_o);

  // R7
  stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running_o) |-> $past(frame_done_i));

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_cmd_o && !run_wr) |=> $stable(cfg_active_o));

  // R9
  te_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_w[dispc_pkg::IB_TE]) |-> $past(te_en_q, 2));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_w[dispc_pkg::IB_ERR]) |-> $past(underflow_i));

  // R5
  vsync_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_w[dispc_pkg::IB_VSYNC]) |-> $past(frame_bound_i));
endmodule

bind dispc_ctrl_core dispc_ctrl_core_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .IRQ_W(IRQ_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .frame_done_i(frame_done_i), .frame_bound_i(frame_bound_i),
  .underflow_i(underflow_i), .irq_o(irq_o), .running_o(running_o),
  .mode_cmd_o(mode_cmd_o), .cfg_active_o(cfg_active_o),
  .sts_w(sts_w), .te_en_q(te_en_q)
);

// File: tb/dispc_ctrl_core_tb_top.sv
module dispc_ctrl_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic frame_done = 1'b0, frame_bound = 1'b0, underflow = 1'b0;
  logic te_pad = 1'b0, te_int = 1'b0;
  logic irq, running, mode_cmd, halt_en;
  logic [31:0] active;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispc_ctrl_core dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .frame_done_i(frame_done),
    .frame_bound_i(frame_bound), .underflow_i(underflow), .te_pad_i(te_pad),
    .te_int_i(te_int), .irq_o(irq), .running_o(running), .mode_cmd_o(mode_cmd),
    .halt_en_o(halt_en), .cfg_active_o(active)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: read data with no expected entry, actual %h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();  @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0; endtask
  task automatic pulse_bound(); @(negedge clk); frame_bound = 1; @(negedge clk); frame_bound = 0; endtask

  task automatic finish_run();
    cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    // R1 reset state
    check(running, 0, "R1 running");
    check(irq, 0, "R1 irq");
    check(active, 0, "R1 active");
    check(mode_cmd, 0, "R1 mode");
    rd_exp(12'h1E8, 0, "R1 status");
    rd_exp(12'h1E0, 0, "R1 enable");

    // R10 / R2: underflow sets status while disabled
    @(negedge clk); underflow = 1; @(negedge clk); underflow = 0;
    cyc(2);
    rd_exp(12'h1E8, 32'h04, "R10 underflow status");
    check(irq, 0, "R2 irq masked");
    wr(12'h1E0, 32'h04); cyc(2);
    check(irq, 1, "R2 irq enabled");
    // R3 partial clear, then full clear
    @(negedge clk); underflow = 1; @(negedge clk); underflow = 0;
    wr(12'h1E4, 32'h01); cyc(2);
    rd_exp(12'h1E8, 32'h04, "R3 unrelated clear keeps bit");
    wr(12'h1E4, 32'hFF); cyc(2);
    rd_exp(12'h1E8, 0, "R3 clear all");
    check(irq, 0, "R2 irq drops");
    wr(12'h1E0, 0);

    // R4 video update while stopped
    wr(12'h024, 32'hA5A5_0001);
    wr(12'h004, 32'h4); cyc(3);
    check(active, 32'hA5A5_0001, "R4 immediate commit");
    rd_exp(12'h1E8, 32'h10, "R4 update done");
    wr(12'h1E4, 32'hFF);

    // R5 video update while running waits for boundary
    wr(12'h004, 32'h1);
    check(running, 1, "R11 run starts");
    wr(12'h024, 32'h0000_1234);
    wr(12'h004, 32'h4); cyc(3);
    check(active, 32'hA5A5_0001, "R5 deferred");
    rd_exp(12'h004, 32'h5, "R11 ctrl readback");
    rd_exp(12'h1E8, 0, "R5 no update yet");
    pulse_bound(); cyc(3);
    check(active, 32'h0000_1234, "R5 commit at boundary");
    rd_exp(12'h1E8, 32'h30, "R5 update+vsync");
    wr(12'h1E4, 32'hFF);

    // R7 stop handling
    pulse_done(); cyc(3);
    check(running, 1, "R7 done without stop ignored");
    rd_exp(12'h1E8, 0, "R7 no done status");
    wr(12'h004, 32'h2);
    rd_exp(12'h004, 32'h3, "R7 stop pending");
    check(running, 1, "R7 still running");
    pulse_done(); cyc(3);
    check(running, 0, "R7 stopped");
    rd_exp(12'h1E8, 32'h01, "R7 done status");
    wr(12'h1E4, 32'hFF);

    // R9 tearing effect
    te_pad = 1; cyc(8);
    rd_exp(12'h1E8, 0, "R9 disabled");
    te_pad = 0;
    wr(12'h1F0, 32'h500); cyc(6);
    te_pad = 1; cyc(8);
    rd_exp(12'h1E8, 32'h02, "R9 pad edge");
    wr(12'h1E4, 32'hFF);
    te_pad = 0;
    wr(12'h1F0, 32'h100); cyc(6);
    te_pad = 1; cyc(8);
    rd_exp(12'h1E8, 0, "R9 pad ignored when internal selected");
    te_int = 1; cyc(8);
    rd_exp(12'h1E8, 32'h02, "R9 internal edge");
    wr(12'h1E4, 32'hFF);
    rd_exp(12'h1F0, 32'h100, "R11 ifctl readback");
    wr(12'h1F0, 32'h10000);
    check(halt_en, 1, "R11 halt");

    // R6 / R8 command mode
    wr(12'h008, 32'h1);
    check(mode_cmd, 1, "R6 mode");
    wr(12'h024, 32'h0000_BEEF);
    wr(12'h004, 32'h4); cyc(3);
    check(active, 32'h0000_1234, "R6 update ignored");
    rd_exp(12'h1E8, 0, "R6 no update done");
    wr(12'h004, 32'h1);
    check(active, 32'h0000_BEEF, "R6 capture on run");
    wr(12'h024, 32'h0000_CAFE);
    wr(12'h004, 32'h1); cyc(2);
    check(active, 32'h0000_BEEF, "R6 run while running ignored");
    pulse_done(); cyc(3);
    check(running, 0, "R8 frame end");
    rd_exp(12'h1E8, 32'h01, "R8 done status");
    rd_exp(12'h024, 32'h0000_CAFE, "R11 staged readback");
    rd_exp(12'h028, 32'h0000_BEEF, "R11 active readback");

    cyc(2);
    finish_run();
  end
endmodule